// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block moves incoming frames into memory by following a singly linked chain of four-word receive descriptors. Software builds the chain, marks each descriptor as owned by hardware and writes the address of the first one to the head input. The walker reads that descriptor and waits for a frame. It packs the frame bytes into the descriptor's buffer, then writes back the received length and status flags, clearing ownership. After that it moves on to the next descriptor.

A null next pointer ends the chain. The walker marks that descriptor end-of-queue and goes idle until software writes the head input again. A completion raises a receive event. The event stays high until software acknowledges the descriptor that completed last. A frame that arrives while no owned descriptor is ready is dropped and counted.

Descriptor layout, as word addresses from the descriptor base:
- +0: next descriptor (0 ends the chain)
- +1: buffer word address
- +2: buffer length in bytes, bits 15:0
- +3: flags in bits 31:16 and received length in bits 15:0

Flag values are 0x8000 start-of-frame, 0x4000 end-of-frame, 0x2000 hardware-owned, 0x1000 end-of-queue and 0x0800 truncated. The maximum length input is normally 1522: a 1518-byte frame with FCS plus a 4-byte VLAN tag.

Top module: `rxw_walker`

## Requirements
- R1: After reset rx_event_o is 0 and overrun_cnt_o is 0. The walker is idle and issues no memory request until the head input is written.
- R2: A head write while idle reads words +0..+3 of the descriptor. If flag 0x2000 (bit 29 of word +3) is set, the next frame is stored from the buffer word address onward, little-endian within each 32-bit word, with mem_be_o marking the bytes written.
- R3: On frame end the walker writes word +3 as {flags, length}. The flags have 0x8000 and 0x4000 set and 0x2000 cleared, and the length is the number of bytes stored.
- R4: A non-zero next pointer makes the walker fetch that descriptor. The following frame lands in it, and the first descriptor's flags do not carry 0x1000.
- R5: A zero next pointer sets 0x1000 in that descriptor's flags and leaves the walker idle. Later frames are dropped until a new head write restarts reception.
- R6: A descriptor without flag 0x2000 is left unmodified. The walker goes idle and later frames are dropped.
- R7: A frame whose start arrives while no owned descriptor is ready is dropped. This covers the idle state and a descriptor fetch in progress. overrun_cnt_o increments by one and no memory byte changes.
- R8: Bytes beyond min(buffer length - offset, max_len_i) are not written. The recorded length equals that limit and flag 0x0800 is set.
- R9: The first byte of a frame is placed buf_off_i bytes past the start of the buffer.
- R10: rx_event_o rises after a completion write. It stays high through acknowledges whose address differs from the last completed descriptor and falls after an acknowledge of that address.
- R11: A head write while the walker is not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_we_i | input | 1 | Head pointer write strobe |
| head_ptr_i | input | AW | Descriptor word address to start from |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_ptr_i | input | AW | Address of a descriptor software has processed |
| max_len_i | input | 16 | Largest frame length accepted, in bytes |
| buf_off_i | input | 16 | Bytes skipped at the start of each buffer |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_sop_i | input | 1 | First byte of a frame |
| rx_eop_i | input | 1 | Last byte of a frame |
| rx_data_i | input | 8 | Frame byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables of a write |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| rx_event_o | output | 1 | Receive completion event |
| overrun_cnt_o | output | CW | Dropped frame count, saturating |

## Verification
A wrong walk state shows up in memory within a frame. A descriptor that is skipped, refetched or left owned leaves word +3 holding its old value. It also leaves bytes in the wrong buffer or makes a dropped frame bump overrun_cnt_o. A wrong byte-lane or offset register corrupts the first or last partial word, so the bench compares every stored byte and the sentinel bytes just outside the stored range. A stale last-completed address shows as rx_event_o failing to fall, or falling early, one cycle after the acknowledge.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int LW = 16;
  localparam logic [15:0] FLG_SOP = 16'h8000;
  localparam logic [15:0] FLG_EOP = 16'h4000;
  localparam logic [15:0] FLG_OWN = 16'h2000;
  localparam logic [15:0] FLG_EOQ = 16'h1000;
  localparam logic [15:0] FLG_ERR = 16'h0800;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CHK,
    ST_READY, ST_RECV, ST_DONE, ST_STAT
  } st_e;
endpackage

// File: rtl/rxw_pack.sv
module rxw_pack #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          byte_v_i,
  input  logic [7:0]    byte_i,
  input  logic          eop_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] off_i,
  input  logic [LW-1:0] limit_i,
  output logic          wr_v_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic [3:0]    wr_be_o,
  output logic [LW-1:0] count_o,
  output logic          trunc_o
);
  logic [LW-1:0] pos_q, cnt_q, lim_q, pos_c, cnt_c, lim_c;
  logic [AW-1:0] base_q, base_c;
  logic [31:0]   acc_q, acc_c, acc_n;
  logic [3:0]    be_q, be_c, be_n;
  logic          trunc_q, trc_c, keep, emit;
  logic [1:0]    lane;

  always_comb begin
    pos_c  = start_i ? off_i   : pos_q;
    cnt_c  = start_i ? '0      : cnt_q;
    lim_c  = start_i ? limit_i : lim_q;
    base_c = start_i ? base_i  : base_q;
    acc_c  = start_i ? '0      : acc_q;
    be_c   = start_i ? '0      : be_q;
    trc_c  = start_i ? 1'b0    : trunc_q;
    keep   = byte_v_i && (cnt_c < lim_c);
    lane   = pos_c[1:0];
    acc_n  = acc_c;
    be_n   = be_c;
    if (keep) begin
      acc_n[8*lane +: 8] = byte_i;
      be_n[lane]         = 1'b1;
    end
    // full word, or leftover partial word at frame end
    emit = byte_v_i && ((keep && lane == 2'd3) || (eop_i && be_n != 4'h0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0; cnt_q <= '0; lim_q <= '0; base_q <= '0;
      acc_q <= '0; be_q <= '0; trunc_q <= 1'b0;
      wr_v_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0; wr_be_o <= '0;
    end else begin
      wr_v_o <= emit;
      if (emit) begin
        wr_addr_o <= base_c + AW'(pos_c >> 2);
        wr_data_o <= acc_n;
        wr_be_o   <= be_n;
      end
      if (start_i || byte_v_i) begin
        pos_q   <= keep ? pos_c + 1'b1 : pos_c;
        cnt_q   <= keep ? cnt_c + 1'b1 : cnt_c;
        lim_q   <= lim_c;
        base_q  <= base_c;
        trunc_q <= trc_c | (byte_v_i && !keep);
        acc_q   <= emit ? '0 : acc_n;
        be_q    <= emit ? '0 : be_n;
      end
    end
  end

  assign count_o = cnt_q;
  assign trunc_o = trunc_q;
endmodule

// File: rtl/rxw_event.sv
module rxw_event #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [AW-1:0] done_ptr_i,
  input  logic          ack_we_i,
  input  logic [AW-1:0] ack_ptr_i,
  output logic          event_o
);
  logic [AW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      event_o <= 1'b0;
    end else if (done_i) begin
      last_q  <= done_ptr_i;
      event_o <= 1'b1;
    end else if (ack_we_i && ack_ptr_i == last_q) begin
      event_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rxw_count.sv
module rxw_count #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rxw_walker.sv
module rxw_walker
  import rxw_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          head_we_i,
  input  logic [AW-1:0] head_ptr_i,
  input  logic          ack_we_i,
  input  logic [AW-1:0] ack_ptr_i,
  input  logic [15:0]   max_len_i,
  input  logic [15:0]   buf_off_i,
  input  logic          rx_valid_i,
  input  logic          rx_sop_i,
  input  logic          rx_eop_i,
  input  logic [7:0]    rx_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          rx_event_o,
  output logic [CW-1:0] overrun_cnt_o
);
  st_e           st_q;
  logic [AW-1:0] ptr_q, nxt_q, buf_q;
  logic [LW-1:0] blen_q, room, limit;
  logic          start, byte_v, drop;
  logic          pk_v, pk_trunc;
  logic [AW-1:0] pk_addr;
  logic [31:0]   pk_data;
  logic [3:0]    pk_be;
  logic [LW-1:0] pk_count;
  logic [15:0]   flags;

  assign room   = (blen_q >= buf_off_i) ? blen_q - buf_off_i : '0;
  assign limit  = (room < max_len_i) ? room : max_len_i;
  assign start  = (st_q == ST_READY) && rx_valid_i && rx_sop_i;
  assign byte_v = start || ((st_q == ST_RECV) && rx_valid_i);
  assign drop   = rx_valid_i && rx_sop_i && (st_q != ST_READY) && (st_q != ST_RECV);
  assign flags  = FLG_SOP | FLG_EOP | ((nxt_q == '0) ? FLG_EOQ : 16'h0)
                | (pk_trunc ? FLG_ERR : 16'h0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ptr_q <= '0; nxt_q <= '0; buf_q <= '0; blen_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (head_we_i) begin ptr_q <= head_ptr_i; st_q <= ST_RD0; end
        ST_RD0:   st_q <= ST_RD1;
        ST_RD1:   begin nxt_q <= mem_rdata_i[AW-1:0]; st_q <= ST_RD2; end
        ST_RD2:   begin buf_q <= mem_rdata_i[AW-1:0]; st_q <= ST_RD3; end
        ST_RD3:   begin blen_q <= mem_rdata_i[LW-1:0]; st_q <= ST_CHK; end
        ST_CHK:   st_q <= mem_rdata_i[16 + 13] ? ST_READY : ST_IDLE;
        ST_READY: if (start) st_q <= rx_eop_i ? ST_DONE : ST_RECV;
        ST_RECV:  if (rx_valid_i && rx_eop_i) st_q <= ST_DONE;
        ST_DONE:  st_q <= ST_STAT;
        ST_STAT:  begin
          if (nxt_q == '0) st_q <= ST_IDLE;
          else begin ptr_q <= nxt_q; st_q <= ST_RD0; end
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0;
    mem_wdata_o = '0; mem_be_o = '0;
    unique case (st_q)
      ST_RD0: begin mem_req_o = 1'b1; mem_addr_o = ptr_q; end
      ST_RD1: begin mem_req_o = 1'b1; mem_addr_o = ptr_q + AW'(1); end
      ST_RD2: begin mem_req_o = 1'b1; mem_addr_o = ptr_q + AW'(2); end
      ST_RD3: begin mem_req_o = 1'b1; mem_addr_o = ptr_q + AW'(3); end
      ST_STAT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = ptr_q + AW'(3);
        mem_wdata_o = {flags, pk_count}; mem_be_o = 4'hF;
      end
      default: ;
    endcase
    if (pk_v) begin
      mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = pk_addr;
      mem_wdata_o = pk_data; mem_be_o = pk_be;
    end
  end

  rxw_pack #(.AW(AW), .LW(LW)) u_pack (
    .clk_i, .rst_ni, .start_i(start), .byte_v_i(byte_v), .byte_i(rx_data_i),
    .eop_i(rx_eop_i), .base_i(buf_q), .off_i(buf_off_i), .limit_i(limit),
    .wr_v_o(pk_v), .wr_addr_o(pk_addr), .wr_data_o(pk_data), .wr_be_o(pk_be),
    .count_o(pk_count), .trunc_o(pk_trunc)
  );

  rxw_event #(.AW(AW)) u_event (
    .clk_i, .rst_ni, .done_i(st_q == ST_STAT), .done_ptr_i(ptr_q),
    .ack_we_i, .ack_ptr_i, .event_o(rx_event_o)
  );

  rxw_count #(.CW(CW)) u_ovr (
    .clk_i, .rst_ni, .inc_i(drop), .cnt_o(overrun_cnt_o)
  );
endmodule

// File: rtl/rxw_walker_chk.sv
module rxw_walker_chk
  import rxw_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [3:0]    mem_be_o,
  input logic [31:0]   mem_wdata_o,
  input logic          rx_event_o,
  input logic          ack_we_i,
  input logic [CW-1:0] overrun_cnt_o,
  input logic          rx_valid_i,
  input logic          rx_sop_i,
  input st_e           st_q
);
  assert_be_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_be_o != 4'h0);

  assert_status_clears_own_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_STAT |-> mem_req_o && mem_we_o && mem_wdata_o[31] && mem_wdata_o[30]
                        && !mem_wdata_o[29]);

  assert_event_falls_on_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_event_o) |-> $past(ack_we_i));

  assert_event_rises_after_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_event_o) |-> $past(mem_req_o && mem_we_o));

  assert_overrun_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_cnt_o != $past(overrun_cnt_o) |-> $past(rx_valid_i && rx_sop_i));
endmodule

bind rxw_walker rxw_walker_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .rx_event_o(rx_event_o),
  .ack_we_i(ack_we_i), .overrun_cnt_o(overrun_cnt_o), .rx_valid_i(rx_valid_i),
  .rx_sop_i(rx_sop_i), .st_q(st_q)
);

// File: tb/rxw_walker_test.sv
module rxw_walker_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [31:0] SENT = 32'hEEEE_EEEE;
  // {frame len, offset, buffer len, max len, expected len, expected error}
  localparam int VEC [8][6] = '{
    '{1, 0, 64, 1522, 1, 0},   '{4, 0, 64, 1522, 4, 0},
    '{7, 1, 64, 1522, 7, 0},   '{13, 3, 64, 1522, 13, 0},
    '{20, 0, 16, 1522, 16, 1}, '{20, 2, 16, 1522, 14, 1},
    '{30, 0, 64, 10, 10, 1},   '{64, 0, 64, 1522, 64, 0}
  };

  logic clk = 0, rst_n = 0;
  logic head_we = 0, ack_we = 0;
  logic [AW-1:0] head_ptr = '0, ack_ptr = '0;
  logic [15:0] max_len = 16'd1522, buf_off = '0;
  logic rx_valid = 0, rx_sop = 0, rx_eop = 0;
  logic [7:0] rx_data = '0;
  logic mem_req, mem_we, rx_event;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [CW-1:0] ovr;
  logic tb_we = 0;
  logic [7:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] mem [256];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  rxw_walker #(.AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .head_we_i(head_we), .head_ptr_i(head_ptr),
    .ack_we_i(ack_we), .ack_ptr_i(ack_ptr), .max_len_i(max_len), .buf_off_i(buf_off),
    .rx_valid_i(rx_valid), .rx_sop_i(rx_sop), .rx_eop_i(rx_eop), .rx_data_i(rx_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata),
    .rx_event_o(rx_event), .overrun_cnt_o(ovr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_addr = 8'(a); tb_data = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic fill(int a, int n);
    for (int i = 0; i < n; i++) poke(a + i, SENT);
  endtask

  task automatic desc(int a, int nxt, int bufa, int blen, logic [31:0] w3);
    poke(a, 32'(nxt)); poke(a + 1, 32'(bufa)); poke(a + 2, 32'(blen)); poke(a + 3, w3);
  endtask

  task automatic head(int p);
    @(negedge clk); head_we = 1; head_ptr = AW'(p);
    @(negedge clk); head_we = 0;
  endtask

  task automatic ack(int p);
    @(negedge clk); ack_we = 1; ack_ptr = AW'(p);
    @(negedge clk); ack_we = 0;
  endtask

  task automatic send(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + i); rx_sop = (i == 0); rx_eop = (i == n - 1);
    end
    @(negedge clk); rx_valid = 0; rx_sop = 0; rx_eop = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] bget(int bufa, int p);
    return mem[8'(bufa + p / 4)][8*(p % 4) +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    logic [CW-1:0] o0;
    for (int i = 0; i < 256; i++) mem[i] = SENT;
    idle(3);
    // R1 reset state
    chk("R1 event", 32'(rx_event), 0);
    chk("R1 overrun", 32'(ovr), 0);
    chk("R1 no request", 32'(mem_req), 0);
    rst_n = 1;
    idle(3);
    chk("R1 idle after reset", 32'(mem_req), 0);

    // table walk: one descriptor, null next; R2 R3 R5 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      int n, off, el, ee, seed;
      n = VEC[v][0]; off = VEC[v][1]; el = VEC[v][4]; ee = VEC[v][5]; seed = v * 16 + 1;
      fill(8'h40, 18);
      desc(8'h10, 0, 8'h40, VEC[v][2], 32'h2000_0000);
      buf_off = 16'(off); max_len = 16'(VEC[v][3]);
      head(8'h10);
      idle(8);
      send(n, seed);
      idle(6);
      chk($sformatf("R3 R5 R8 status v%0d", v), mem[8'h13],
          {16'hD000 | (ee != 0 ? 16'h0800 : 16'h0), 16'(el)});
      bad = 0;
      for (int i = 0; i < el; i++) if (bget(8'h40, off + i) !== 8'(seed + i)) bad++;
      chk($sformatf("R2 R9 data v%0d", v), 32'(bad), 0);
      chk($sformatf("R8 sentinel after v%0d", v), 32'(bget(8'h40, off + el)), 32'hEE);
      if (off > 0) chk($sformatf("R9 sentinel before v%0d", v), 32'(bget(8'h40, off - 1)), 32'hEE);
      chk($sformatf("R10 event high v%0d", v), 32'(rx_event), 1);
      ack(8'h10);
      idle(1);
      chk($sformatf("R10 event cleared v%0d", v), 32'(rx_event), 0);
    end
    buf_off = 0; max_len = 16'd1522;

    // R4 chain of two, R10 mismatched ack
    fill(8'h40, 4); fill(8'h60, 4);
    desc(8'h10, 8'h20, 8'h40, 64, 32'h2000_0000);
    desc(8'h20, 0, 8'h60, 64, 32'h2000_0000);
    head(8'h10);
    idle(8);
    send(5, 8'h30);
    idle(12);
    send(3, 8'h50);
    idle(6);
    chk("R4 first status no EOQ", mem[8'h13], 32'hC000_0005);
    chk("R4 second status", mem[8'h23], 32'hD000_0003);
    chk("R4 second data", mem[8'h60], 32'hEE52_5150);
    ack(8'h10);
    idle(1);
    chk("R10 wrong ack keeps event", 32'(rx_event), 1);
    ack(8'h20);
    idle(1);
    chk("R10 matching ack clears", 32'(rx_event), 0);

    // R5 R7 frame after end of chain dropped
    o0 = ovr;
    send(4, 8'h70);
    idle(4);
    chk("R5 R7 overrun after chain end", 32'(ovr), 32'(o0 + 1));
    chk("R5 R7 memory untouched", mem[8'h23], 32'hD000_0003);
    chk("R7 no request while idle", 32'(mem_req), 0);

    // R6 descriptor not owned
    fill(8'h80, 2);
    desc(8'h30, 0, 8'h80, 64, 32'h0000_1234);
    head(8'h30);
    idle(8);
    o0 = ovr;
    send(3, 8'h11);
    idle(6);
    chk("R6 descriptor untouched", mem[8'h33], 32'h0000_1234);
    chk("R6 buffer untouched", mem[8'h80], SENT);
    chk("R6 frame counted", 32'(ovr), 32'(o0 + 1));

    // R7 frame during fetch dropped, next frame stored
    fill(8'h40, 2);
    desc(8'h10, 0, 8'h40, 64, 32'h2000_0000);
    o0 = ovr;
    head(8'h10);
    send(3, 8'h21);
    idle(6);
    chk("R7 fetch-time frame counted", 32'(ovr), 32'(o0 + 1));
    send(4, 8'hA0);
    idle(6);
    chk("R7 later frame stored", mem[8'h40], 32'hA3A2_A1A0);
    chk("R7 later status", mem[8'h13], 32'hD000_0004);
    ack(8'h10);

    // R11 head write while waiting for a frame is ignored
    fill(8'h40, 2); fill(8'h60, 2);
    desc(8'h10, 0, 8'h40, 64, 32'h2000_0000);
    desc(8'h20, 0, 8'h60, 64, 32'h2000_0000);
    head(8'h10);
    idle(8);
    head(8'h20);
    idle(2);
    send(2, 8'h05);
    idle(6);
    chk("R11 first descriptor filled", mem[8'h13], 32'hD000_0002);
    chk("R11 second descriptor untouched", mem[8'h23], 32'h2000_0000);
    chk("R11 second buffer untouched", mem[8'h60], SENT);
    ack(8'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule